// File: doc/BRIEF.md
# UART Modem Control and Status Logic

This block holds the modem-side register pair of a 16550-style serial controller. A CPU-side register port writes the modem control register and reads the modem status register. The control register holds the request-to-send bit. The block turns that bit into the active-low `rts_no` pin, and three other conditions can force the pin inactive.

On the status side the ring-indicator input passes through a synchronizer. Its level is shown in the status register. A LOW-to-HIGH change on it sets a sticky change flag. The flag stays set until the status register is read, and it raises the modem-status interrupt request while that interrupt is enabled. The interrupt enable, the loopback mode and the auto-RTS mode come from neighbouring registers as plain inputs. The receive-threshold stop request also comes from a neighbour.

Top module: `uart_modem_ctrl`

## Requirements
- R1: After reset is asserted, `rts_no` is 1, `irq_o` is 0, the control register reads 0x00 and status bit 2 reads 0.
- R2: `addr_i`=0 selects the control register and `addr_i`=1 selects the status register. A write with `wr_en_i`=1 and `addr_i`=0 stores `wdata_i[1]` as the RTS bit. `rdata_o` shows the selected register in the same cycle; the control register reads as the RTS bit in bit 1 and zeros elsewhere.
- R3: With the RTS bit set, loopback off and no forced stop, `rts_no` is 0. It changes one clock after the register updates, so two edges after the write.
- R4: Clearing the RTS bit drives `rts_no` to 1, with the same latency as R3.
- R5: While `loopback_i` is 1, `rts_no` is 1 from the next edge on, whatever the RTS bit holds.
- R6: While `auto_rts_en_i` and `rx_stop_i` are both 1, `rts_no` is 1 from the next edge on. With `auto_rts_en_i`=0, `rx_stop_i` has no effect on `rts_no`.
- R7: Status bit 6 shows `ri_i` after a two-flop synchronizer. A change on `ri_i` shows in `rdata_o` after two clock edges.
- R8: A LOW-to-HIGH change of the synchronized ring input sets status bit 2 on the third edge after `ri_i` rises. A HIGH-to-LOW change does not set it.
- R9: Status bit 2 stays set until a read of the status register, which is `rd_en_i`=1 with `addr_i`=1. That read returns the set value and clears the bit at the same edge. Looking at `rdata_o` without `rd_en_i`, and reads of the control register, leave the bit unchanged.
- R10: If a rising edge is detected in the same cycle as the status read, status bit 2 is set again rather than cleared.
- R11: `irq_o` is 1 exactly when status bit 2 is set and `ier_msi_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect on status read) |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| loopback_i | input | 1 | Loopback mode active |
| auto_rts_en_i | input | 1 | Auto-RTS mode enable |
| rx_stop_i | input | 1 | Receive-threshold request to deassert RTS |
| ier_msi_i | input | 1 | Modem-status interrupt enable |
| ri_i | input | 1 | Ring indicator pin (asynchronous) |
| rts_no | output | 1 | Request-to-send pin, active low |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The properties take the mode inputs, the stop request and the register strobes to be synchronous to `clk_i`. Only `ri_i` may change at any time, and it is checked only after the synchronizer. The bench changes every input on the falling edge, so each one is stable at the rising edge that samples it. It holds `ri_i` low through reset, so that the flag starts from a known edge history. It also keeps the ring input steady long enough that each rising edge and each read fall in the cycle the test means to hit, including the case where an edge and a read land together.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int MCR_RTS_BIT  = 1;
  localparam int MSR_TERI_BIT = 2;
  localparam int MSR_RI_BIT   = 6;

  typedef enum logic {
    REG_MCR = 1'b0,
    REG_MSR = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/uart_ri_flag.sv
module uart_ri_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ri_sync_i,
  input  logic clr_i,
  output logic rise_o,
  output logic flag_o
);
  logic prev_q, flag_q;

  assign rise_o = ri_sync_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= ri_sync_i;
      // an edge in the clearing cycle wins
      flag_q <= rise_o | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_mcr_reg.sv
module uart_mcr_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rts_bit_o
);
  import uart_modem_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rts_bit_o <= 1'b0;
    else if (wr_i) rts_bit_o <= wdata_i[MCR_RTS_BIT];
  end
endmodule

// File: rtl/uart_rts_drive.sv
module uart_rts_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rts_bit_i,
  input  logic loopback_i,
  input  logic auto_rts_en_i,
  input  logic rx_stop_i,
  output logic rts_no
);
  logic force_off;

  assign force_off = loopback_i | (auto_rts_en_i & rx_stop_i);

  // registered so the pin never glitches between sources
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_no <= 1'b1;
    else         rts_no <= ~(rts_bit_i & ~force_off);
  end
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              loopback_i,
  input  logic              auto_rts_en_i,
  input  logic              rx_stop_i,
  input  logic              ier_msi_i,
  input  logic              ri_i,
  output logic              rts_no,
  output logic              irq_o
);
  import uart_modem_pkg::*;

  logic rts_bit, ri_sync, ri_rise, teri_flag;
  logic mcr_wr, msr_rd;

  assign mcr_wr = wr_en_i & (reg_sel_e'(addr_i) == REG_MCR);
  assign msr_rd = rd_en_i & (reg_sel_e'(addr_i) == REG_MSR);

  uart_mcr_reg #(.DATA_W(DATA_W)) mcr_i (
    .clk_i, .rst_ni, .wr_i(mcr_wr), .wdata_i, .rts_bit_o(rts_bit)
  );

  uart_rts_drive rts_i (
    .clk_i, .rst_ni, .rts_bit_i(rts_bit), .loopback_i,
    .auto_rts_en_i, .rx_stop_i, .rts_no
  );

  uart_sync #(.STAGES(SYNC_STAGES)) ri_sync_i (
    .clk_i, .rst_ni, .d_i(ri_i), .q_o(ri_sync)
  );

  uart_ri_flag ri_flag_i (
    .clk_i, .rst_ni, .ri_sync_i(ri_sync), .clr_i(msr_rd),
    .rise_o(ri_rise), .flag_o(teri_flag)
  );

  always_comb begin
    rdata_o = '0;
    if (reg_sel_e'(addr_i) == REG_MCR) begin
      rdata_o[MCR_RTS_BIT] = rts_bit;
    end else begin
      rdata_o[MSR_RI_BIT]   = ri_sync;
      rdata_o[MSR_TERI_BIT] = teri_flag;
    end
  end

  assign irq_o = teri_flag & ier_msi_i;
endmodule

// File: rtl/uart_modem_ctrl_chk.sv
module uart_modem_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              loopback_i,
  input logic              auto_rts_en_i,
  input logic              rx_stop_i,
  input logic              ier_msi_i,
  input logic              rts_no,
  input logic              irq_o,
  input logic              ri_rise,
  input logic              flag
);
  // R5
  loopback_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loopback_i |=> rts_no);

  // R6
  auto_rts_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && rx_stop_i) |=> rts_no);

  // R4
  mcr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && !wdata_i[1]) |=> ##1 rts_no);

  // R8
  ri_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_rise |=> flag);

  // R9
  msr_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i && !ri_rise) |=> !flag);

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !(rd_en_i && addr_i)) |=> flag);

  // R11
  irq_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_msi_i |-> !irq_o);
endmodule

bind uart_modem_ctrl uart_modem_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .loopback_i(loopback_i),
  .auto_rts_en_i(auto_rts_en_i), .rx_stop_i(rx_stop_i),
  .ier_msi_i(ier_msi_i), .rts_no(rts_no), .irq_o(irq_o),
  .ri_rise(ri_rise), .flag(teri_flag)
);

// File: tb/uart_modem_ctrl_tb_top.sv
module uart_modem_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       loopback = 1'b0, auto_en = 1'b0, rx_stop = 1'b0;
  logic       msi_en = 1'b0, ri = 1'b0;
  logic       rts_n, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_modem_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .loopback_i(loopback), .auto_rts_en_i(auto_en), .rx_stop_i(rx_stop),
    .ier_msi_i(msi_en), .ri_i(ri), .rts_no(rts_n), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // advance n rising edges, return at the falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mcr(input logic [7:0] d);
    wr_en = 1'b1; addr = 1'b0; wdata = d;
    step(1);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] peek_msr();
    return 8'h00;
  endfunction

  // status read with side effect; returns value seen in the read cycle
  task automatic read_msr(output logic [7:0] v);
    addr = 1'b1; rd_en = 1'b1; #1;
    v = rdata;
    step(1);
    rd_en = 1'b0;
  endtask

  task automatic look(input logic a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rst_n = 1'b0; step(2);
    check("R1 rts", {7'b0, rts_n}, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);
    look(1'b0, v); check("R1 mcr", v, 8'h00);
    look(1'b1, v); check("R1 msr bit2", v & 8'h04, 8'h00);
    rst_n = 1'b1; step(1);
  endtask

  task automatic t_mcr_rts();
    logic [7:0] v;
    write_mcr(8'hFF);
    look(1'b0, v); check("R2 mcr readback", v, 8'h02);
    check("R3 rts not yet", {7'b0, rts_n}, 8'h01);
    step(1); check("R3 rts active", {7'b0, rts_n}, 8'h00);
    write_mcr(8'hFD);
    look(1'b0, v); check("R2 mcr cleared", v, 8'h00);
    step(1); check("R4 rts inactive", {7'b0, rts_n}, 8'h01);
    write_mcr(8'h02); step(1);
    check("R3 rts active again", {7'b0, rts_n}, 8'h00);
  endtask

  task automatic t_loopback();
    loopback = 1'b1; step(1);
    check("R5 loopback forces high", {7'b0, rts_n}, 8'h01);
    step(3); check("R5 held", {7'b0, rts_n}, 8'h01);
    loopback = 1'b0; step(1);
    check("R5 released", {7'b0, rts_n}, 8'h00);
  endtask

  task automatic t_auto_rts();
    rx_stop = 1'b1; step(2);
    check("R6 stop ignored w/o auto", {7'b0, rts_n}, 8'h00);
    auto_en = 1'b1; step(1);
    check("R6 auto stop", {7'b0, rts_n}, 8'h01);
    rx_stop = 1'b0; step(1);
    check("R6 auto resume", {7'b0, rts_n}, 8'h00);
    auto_en = 1'b0;
  endtask

  task automatic t_ri_level_flag();
    logic [7:0] v;
    ri = 1'b1; step(1);
    look(1'b1, v); check("R7 level before sync", v & 8'h40, 8'h00);
    step(1);
    look(1'b1, v); check("R7 level synced", v & 8'h40, 8'h40);
    check("R8 flag not yet", v & 8'h04, 8'h00);
    step(1);
    look(1'b1, v); check("R8 flag set", v & 8'h04, 8'h04);
    step(4);
    look(1'b1, v); check("R9 peek keeps flag", v & 8'h04, 8'h04);
    addr = 1'b0; rd_en = 1'b1; step(1); rd_en = 1'b0;
    look(1'b1, v); check("R9 mcr read keeps flag", v & 8'h04, 8'h04);
    read_msr(v); check("R9 read returns flag", v & 8'h44, 8'h44);
    look(1'b1, v); check("R9 read clears flag", v & 8'h04, 8'h00);
    ri = 1'b0; step(4);
    look(1'b1, v); check("R8 falling edge no flag", v & 8'h44, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    msi_en = 1'b0;
    ri = 1'b1; step(3);
    check("R11 masked", {7'b0, irq}, 8'h00);
    msi_en = 1'b1; #1;
    check("R11 enabled", {7'b0, irq}, 8'h01);
    read_msr(v);
    check("R11 drops on read", {7'b0, irq}, 8'h00);
    ri = 1'b0; step(3);
  endtask

  task automatic t_edge_on_read();
    logic [7:0] v;
    ri = 1'b1; step(3);
    check("R10 flag preset", {7'b0, irq}, 8'h01);
    ri = 1'b0; step(4);
    ri = 1'b1; step(2);   // rise seen in the cycle that follows
    read_msr(v);
    check("R10 read value", v & 8'h04, 8'h04);
    check("R10 flag re-set", {7'b0, irq}, 8'h01);
    read_msr(v);
    check("R10 next read clears", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_mcr_rts();
    t_loopback();
    t_auto_rts();
    t_ri_level_flag();
    t_irq();
    t_edge_on_read();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule